// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Refresh Scheduling

This block sits between a simple single-bit host port and a 64K x 1 dynamic RAM whose address pins are shared between row and column halves. A host access is a one-cycle request carrying a write flag, a 16-bit address and one data bit. The block turns it into a row strobe with the upper address byte, then a column strobe with the lower byte, and holds both for clock counts derived from nanosecond limits. Read data comes back with a one-cycle valid pulse.

Every timing limit is a parameter in nanoseconds. At elaboration each one is converted to a whole number of clock cycles, rounded so that every minimum is met and every maximum is respected. After reset the block waits out the power-up pause and then issues eight dummy row-strobe cycles. Only then does it raise its ready flag.

From then on an interval timer requests one refresh every window/rows period. A refresh is a row-strobe-only cycle driven from a 7-bit row counter. A pending refresh wins over a new host request at the next idle point. A host cycle that has already started is never cut short.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset all three strobes are high (inactive), `host_ready` is low, and no row strobe falls until at least ceil(PAUSE_NS/CLK_NS) cycles have passed.
- R2: Exactly WARM_CYCLES (8) row-strobe-only cycles are issued before `host_ready` first goes high.
- R3: A host access drives `host_addr[15:8]` on `dram_a` when the row strobe falls and `host_addr[7:0]` when the column strobe falls. The column strobe falls exactly ceil(RCD_NS/CLK_NS) cycles after the row strobe.
- R4: The row strobe stays low for at most floor(RAS_MAX_NS/CLK_NS) cycles. Before each fall it has been high for at least ceil(RP_NS/CLK_NS) cycles. Successive falls are at least ceil(RC_NS/CLK_NS) cycles apart.
- R5: The column strobe is low only while the row strobe is low. It stays low for max(ceil(CAC_NS/CLK_NS), ceil(RAC_NS/CLK_NS)-rcd, ceil(RAS_MIN_NS/CLK_NS)-rcd) cycles, where rcd is the R3 delay.
- R6: A refresh is a row-strobe cycle with the column strobe high throughout. `dram_a[6:0]` carries a row counter that starts at 0 and advances by one (mod 128) per such cycle, and `dram_a[7]` is 0.
- R7: Writes are early writes. `dram_we_n` is low already when the row strobe falls and stays low through the column-strobe fall. `dram_d` equals the host data bit at that fall, and no `host_rvalid` pulse follows a write.
- R8: A read returns `host_rvalid` high for exactly one cycle, rcd+col cycles after the accepting clock edge, where col is the R5 length. `host_rdata` equals the last bit written to that address.
- R9: After initialisation, consecutive refresh starts are at most floor(REF_WINDOW_NS/(REF_ROWS*CLK_NS)) plus one host-cycle length (rcd+col+precharge) cycles apart.
- R10: A request is accepted only on a clock edge where `host_req` and `host_ready` are both high. `host_ready` is high only when both strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, taken when ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address, upper byte row, lower byte column |
| host_wdata | input | 1 | Write data bit |
| host_ready | output | 1 | Idle, initialised and no refresh pending |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| host_rdata | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_a | output | 8 | Multiplexed row/column address |
| dram_d | output | 1 | Data to memory |
| dram_q | input | 1 | Data from memory |

## Verification
The bench keeps the default strobe limits at a 10 ns clock, so the cycle counts checked are the real ones: 3-cycle row-to-column delay, 17-cycle column strobe, 13-cycle precharge and a 33-cycle full cycle. It shortens the power-up pause to 5000 ns and the refresh window to 256000 ns, which gives a 200-cycle refresh interval. With those values the initialisation sequence, many refresh/host collisions and a full wrap of the 128-row refresh counter all fit in a short run.

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int CLK_NS        = 10,
  parameter int PAUSE_NS      = 500_000,
  parameter int WARM_CYCLES   = 8,
  parameter int RP_NS         = 120,
  parameter int RCD_NS        = 25,
  parameter int CAC_NS        = 115,
  parameter int RAC_NS        = 200,
  parameter int RAS_MIN_NS    = 200,
  parameter int RAS_MAX_NS    = 10_000,
  parameter int RC_NS         = 330,
  parameter int REF_WINDOW_NS = 2_000_000,
  parameter int REF_ROWS      = 128,
  parameter int AW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [2*AW-1:0] host_addr,
  input  logic          host_wdata,
  output logic          host_ready,
  output logic          host_rvalid,
  output logic          host_rdata,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic [AW-1:0] dram_a,
  output logic          dram_d,
  input  logic          dram_q
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_PAUSE  = cyc(PAUSE_NS);
  localparam int C_RP     = cyc(RP_NS);
  localparam int C_RCD    = cyc(RCD_NS);
  localparam int C_COL    = imax(cyc(CAC_NS), imax(cyc(RAC_NS), cyc(RAS_MIN_NS)) - C_RCD);
  localparam int C_RASR   = imax(cyc(RAS_MIN_NS), cyc(RAC_NS));
  localparam int C_PRE    = imax(C_RP, cyc(RC_NS) - imax(C_RCD + C_COL, C_RASR));
  localparam int C_RC     = cyc(RC_NS);
  localparam int C_RASMAX = RAS_MAX_NS / CLK_NS;
  localparam int C_REFI   = REF_WINDOW_NS / (REF_ROWS * CLK_NS);
  localparam int CW       = $clog2(C_PAUSE + C_REFI + 64);
  localparam int TW       = $clog2(C_REFI + 1);
  localparam int RB       = $clog2(REF_ROWS);
  localparam int WB       = $clog2(WARM_CYCLES + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_ROW, S_COL, S_RFSH, S_PRE} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tmr;
  logic [WB-1:0]     warm;
  logic [RB-1:0]     rrow;
  logic              pend;
  logic [2*AW-1:0]   lat_addr;
  logic              lat_we;
  logic              lat_d;
  logic              warm_done;

  assign warm_done  = (warm == WB'(WARM_CYCLES));
  assign host_ready = (state == S_IDLE) && !pend;
  assign dram_ras_n = !(state == S_ROW || state == S_COL || state == S_RFSH);
  assign dram_cas_n = (state != S_COL);
  assign dram_we_n  = !((state == S_ROW || state == S_COL) && lat_we);
  assign dram_d     = lat_d;
  assign dram_a     = (state == S_COL)  ? lat_addr[AW-1:0] :
                      (state == S_RFSH) ? {{(AW-RB){1'b0}}, rrow} : lat_addr[2*AW-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_PAUSE;
      cnt         <= CW'(C_PAUSE - 1);
      tmr         <= '0;
      warm        <= '0;
      rrow        <= '0;
      pend        <= 1'b0;
      lat_addr    <= '0;
      lat_we      <= 1'b0;
      lat_d       <= 1'b0;
      host_rvalid <= 1'b0;
      host_rdata  <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        S_PAUSE: if (cnt == '0) begin
          state <= S_RFSH;
          cnt   <= CW'(C_RASR - 1);
        end else cnt <= cnt - 1'b1;
        S_IDLE: if (pend) begin
          state <= S_RFSH;
          cnt   <= CW'(C_RASR - 1);
          pend  <= 1'b0;
        end else if (host_req) begin
          state    <= S_ROW;
          cnt      <= CW'(C_RCD - 1);
          lat_addr <= host_addr;
          lat_we   <= host_we;
          lat_d    <= host_wdata;
        end
        S_ROW: if (cnt == '0) begin
          state <= S_COL;
          cnt   <= CW'(C_COL - 1);
        end else cnt <= cnt - 1'b1;
        S_COL: if (cnt == '0) begin
          state <= S_PRE;
          cnt   <= CW'(C_PRE - 1);
          if (!lat_we) begin
            host_rvalid <= 1'b1;
            host_rdata  <= dram_q;
          end
        end else cnt <= cnt - 1'b1;
        S_RFSH: if (cnt == '0) begin
          state <= S_PRE;
          cnt   <= CW'(C_PRE - 1);
          rrow  <= rrow + 1'b1;
          if (!warm_done) warm <= warm + 1'b1;
        end else cnt <= cnt - 1'b1;
        S_PRE: if (cnt == '0) begin
          if (warm_done) state <= S_IDLE;
          else begin
            state <= S_RFSH;
            cnt   <= CW'(C_RASR - 1);
          end
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
      if (warm_done) begin
        if (tmr == TW'(C_REFI - 1)) begin
          tmr  <= '0;
          pend <= 1'b1;
        end else tmr <= tmr + 1'b1;
      end
    end
  end

  logic [CW-1:0] lo_run, hi_run, since_fall;
  logic          ras_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run     <= '0;
      hi_run     <= '1;
      since_fall <= '1;
      ras_q      <= 1'b1;
    end else begin
      ras_q      <= dram_ras_n;
      lo_run     <= dram_ras_n ? '0 : lo_run + 1'b1;
      hi_run     <= !dram_ras_n ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
      since_fall <= (!dram_ras_n && ras_q) ? CW'(1) :
                    ((since_fall == '1) ? since_fall : since_fall + 1'b1);
    end
  end

  assert_ras_low_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> lo_run < CW'(C_RASMAX));
  assert_precharge_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && ras_q) |-> hi_run >= CW'(C_RP));
  assert_cycle_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && ras_q) |-> since_fall >= CW'(C_RC));
  assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  assert_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
  assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (dram_ras_n && dram_cas_n));

endmodule

// File: tb/dram_seq_ctrl_bench.sv
module dram_seq_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int PAUSE_NS = 5000;
  localparam int WIN_NS = 256000;
  localparam int ROWS = 128;

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PAUSE = up(PAUSE_NS);
  localparam int E_RCD   = up(25);
  localparam int E_COL   = mx(up(115), up(200) - E_RCD);
  localparam int E_RP    = up(120);
  localparam int E_RC    = up(330);
  localparam int E_RASMX = 10000 / CLK_NS;
  localparam int E_RAC   = up(200);
  localparam int E_PRE   = mx(E_RP, E_RC - (E_RCD + E_COL));
  localparam int E_REFI  = WIN_NS / (ROWS * CLK_NS);
  localparam int E_HOST  = E_RCD + E_COL + E_PRE;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, wd = 0;
  logic [15:0] addr = 0;
  logic ready, rvalid, rdata, ras_n, cas_n, we_n, dd;
  logic [7:0] da;
  logic dq = 0;

  always #5 clk = ~clk;

  dram_seq_ctrl #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .REF_WINDOW_NS(WIN_NS),
                  .REF_ROWS(ROWS)) u_dram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
    .host_wdata(wd), .host_ready(ready), .host_rvalid(rvalid), .host_rdata(rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_a(da),
    .dram_d(dd), .dram_q(dq));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  bit mem[int];
  bit shadow[int];
  int cyc = 0;
  logic [15:0] exp_addr = 0;
  logic exp_wd = 0;

  int prev_ras = 1, prev_cas = 1;
  int fall_t = 0, prev_fall_t = -1, rise_t = -1, cas_fall_t = 0;
  logic [7:0] row_l;
  bit cas_seen = 0, we_at_fall = 0;
  int rfsh_cnt = 0, last_rfsh_t = -1, exp_rrow = 0;
  bit first_fall = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc++;
      if (prev_ras == 1 && ras_n == 0) begin
        if (first_fall) chk(cyc > E_PAUSE, "R1 pause before first row strobe", cyc, E_PAUSE);
        else begin
          chk(cyc - rise_t >= E_RP, "R4 precharge", cyc - rise_t, E_RP);
          chk(cyc - prev_fall_t >= E_RC, "R4 cycle time", cyc - prev_fall_t, E_RC);
        end
        first_fall = 0;
        prev_fall_t = cyc;
        fall_t = cyc;
        row_l = da;
        cas_seen = 0;
        we_at_fall = !we_n;
      end
      if (prev_cas == 1 && cas_n == 0) begin
        cas_seen = 1;
        cas_fall_t = cyc;
        chk(ras_n == 0, "R5 column strobe inside row strobe", ras_n, 0);
        chk(cyc - fall_t == E_RCD, "R3 row-to-column delay", cyc - fall_t, E_RCD);
        chk(row_l == exp_addr[15:8], "R3 row half", row_l, exp_addr[15:8]);
        chk(da == exp_addr[7:0], "R3 column half", da, exp_addr[7:0]);
        if (!we_n) begin
          chk(we_at_fall, "R7 write strobe low before strobes", we_at_fall, 1);
          chk(dd == exp_wd, "R7 write data", dd, exp_wd);
          mem[{row_l, da}] = dd;
        end
        dq = mem.exists({row_l, da}) ? mem[{row_l, da}] : 1'b0;
      end
      if (prev_cas == 0 && cas_n == 1)
        chk(cyc - cas_fall_t == E_COL, "R5 column strobe length", cyc - cas_fall_t, E_COL);
      if (prev_ras == 0 && ras_n == 1) begin
        rise_t = cyc;
        chk(cyc - fall_t <= E_RASMX, "R4 row strobe max", cyc - fall_t, E_RASMX);
        chk(cyc - fall_t >= E_RAC, "R5 row strobe covers access", cyc - fall_t, E_RAC);
        if (!cas_seen) begin
          chk(row_l == 8'(exp_rrow), "R6 refresh row", row_l, exp_rrow);
          exp_rrow = (exp_rrow + 1) % ROWS;
          rfsh_cnt++;
          if (rfsh_cnt > 9)
            chk(fall_t - last_rfsh_t <= E_REFI + E_HOST, "R9 refresh spacing",
                fall_t - last_rfsh_t, E_REFI + E_HOST);
          last_rfsh_t = fall_t;
        end
      end
      if (ready) chk(ras_n && cas_n, "R10 ready only with strobes idle", ras_n, 1);
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic do_op(input bit w, input logic [15:0] a, input bit d);
    int n;
    bit seen;
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wd = d;
    exp_addr = a; exp_wd = d;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    addr = $urandom;
    wd = $urandom;
    if (w) begin
      shadow[a] = d;
      seen = 0;
      for (int i = 0; i < E_HOST + 2; i++) begin
        if (rvalid) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R7 no read pulse after write", seen, 0);
    end else begin
      n = 0;
      seen = 0;
      while (n < 100) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (rvalid) begin seen = 1; break; end
      end
      chk(seen && n == E_RCD + E_COL, "R8 read latency", n, E_RCD + E_COL);
      chk(rdata == shadow[a], "R8 read data", rdata, shadow[a]);
      @(negedge clk);
      chk(!rvalid, "R8 single-cycle pulse", rvalid, 0);
    end
  endtask

  logic [15:0] pool[16];

  initial begin
    process::self().srandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ready, "R1 not ready in reset", ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && !ready, "R1 idle after reset release", ras_n, 1);
    req = 1;
    while (!ready) @(negedge clk);
    req = 0;
    chk(rfsh_cnt == 8, "R2 warm-up cycles before ready", rfsh_cnt, 8);
    chk(exp_addr == 0, "R10 request ignored while not ready", exp_addr, 0);

    pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h00FF; pool[3] = 16'hFF00;
    for (int i = 4; i < 16; i++) pool[i] = 16'($urandom);
    do_op(1, 16'h0000, 1);
    do_op(1, 16'hFFFF, 1);
    do_op(0, 16'h0000, 0);
    do_op(0, 16'hFFFF, 0);
    do_op(1, 16'h0000, 0);
    do_op(0, 16'h0000, 0);
    for (int i = 0; i < 16; i++) do_op(1, pool[i], 1'($urandom));
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom % 16;
      if ($urandom % 3 == 0) do_op(1, pool[k], 1'($urandom));
      else do_op(0, pool[k], 0);
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (ROWS * E_REFI + 500) @(negedge clk);
    chk(rfsh_cnt > ROWS + 8, "R6 refresh row counter wrapped", rfsh_cnt, ROWS + 8);
    do_op(0, pool[1], 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule